// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns a single high-level request into the train of bus write cycles that a 16-bit parallel NOR flash needs before it will act on a command. A request names one of four operations: software reset, word program, block erase or whole-device erase. It also carries a 19-bit word address and a data word. The block then plays out the unlock pairs and the command write for that operation on a flash write bus made of page select, window offset, data and a one-clock write strobe. Between strobes it leaves a fixed number of quiet clocks, so that a device much slower than the host can keep up.

The device is seen through a 32K-word window. The upper address bits choose one of 16 pages, and the block holds that page on its page-select output for the whole operation. For block erase the block works out the base of the erase block that holds the target word. Page 0 has four unequal blocks, and every other page is a single block. The request side is a valid/ready handshake. Ready is high only while the block is idle, and a request is taken on the clock edge where valid and ready are both high. A requester that sees ready low must hold its request, or withdraw it, because nothing is queued. A one-clock done pulse marks the end of every operation.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. The operation code is 0 for reset, 1 for word program, 2 for block erase and 3 for device erase. The first write strobe appears in the cycle right after acceptance.
- R2: Block erase issues six writes in this order: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (erase block base, 30h).
- R3: Device erase issues the same first five writes as block erase, then (5555h, 10h).
- R4: Word program issues four writes: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (target offset, request data).
- R5: Reset issues a single write of F0h to the target offset.
- R6: `fl_we` is high for exactly one clock per write. Consecutive strobes of one operation are separated by exactly GAP_CYCLES low clocks.
- R7: `done` is high for exactly one clock, GAP_CYCLES+1 clocks after the last strobe. `req_ready` is low during that clock and high in the next one.
- R8: `fl_page` equals request address bits [18:15] for the whole operation. `fl_addr` is a 15-bit offset within the window.
- R9: The erase block base is 0000h, 2000h, 3000h or 4000h on page 0, for offsets below 2000h, below 3000h, below 4000h and at or above 4000h respectively. On any other page it is 0000h.
- R10: A request presented while the block is busy is ignored. The running sequence is unchanged and no extra write follows it.
- R11: After reset, `req_ready` is high and `fl_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | Operation code (0 reset, 1 program, 2 block erase, 3 device erase) |
| req_addr | input | 19 | Word address: page in [18:15], offset in [14:0] |
| req_data | input | 16 | Word to program |
| fl_page | output | 4 | Flash page select |
| fl_addr | output | 15 | Flash window offset of the current write |
| fl_data | output | 16 | Flash write data |
| fl_we | output | 1 | One-clock write strobe |
| done | output | 1 | One-clock end-of-operation pulse |

## Verification
Two events can meet in the same clock: the done pulse of one operation and a new request waiting at the handshake. The bench drives `req_valid` high in the very cycle that done is seen. It then judges that the request is not taken during the done cycle, but on the following idle cycle, so that the new operation's first strobe falls exactly two clocks after done. A second collision, a request that lands in the middle of a sequence, is raised at a fixed point inside the run and withdrawn before done. The write log must then match the original operation alone.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_PROG   = 2'd1,
    OP_BERASE = 2'd2,
    OP_CERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_STROBE,
    S_WAIT,
    S_DONE
  } st_e;

  localparam logic [15:0] UNLOCK_HI = 16'h5555;
  localparam logic [15:0] UNLOCK_LO = 16'h2AAA;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_ERSET  = 8'h80;
  localparam logic [7:0] CODE_PRSET  = 8'hA0;
  localparam logic [7:0] CODE_BLKCF  = 8'h30;
  localparam logic [7:0] CODE_CHIPCF = 8'h10;
  localparam logic [7:0] CODE_RDARR  = 8'hF0;

  function automatic logic [2:0] op_len(op_e op);
    case (op)
      OP_RESET: op_len = 3'd1;
      OP_PROG:  op_len = 3'd4;
      default:  op_len = 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/nor_gap_timer.sv
module nor_gap_timer #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || expired)   cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R6: wait counter never passes the programmed gap
  assert_gap_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R6: counter restarts after each expiry
  assert_gap_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> cnt == '0);

endmodule

// File: rtl/nor_blk_base.sv
module nor_blk_base #(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  output logic [OFS_W-1:0]  base
);
  localparam logic [OFS_W-1:0] EDGE_A = OFS_W'(1 << (OFS_W - 2));
  localparam logic [OFS_W-1:0] EDGE_B = OFS_W'(3 << (OFS_W - 3));
  localparam logic [OFS_W-1:0] EDGE_C = OFS_W'(1 << (OFS_W - 1));

  always_comb begin
    base = '0;
    if (page == '0) begin
      if (ofs >= EDGE_C)      base = EDGE_C;
      else if (ofs >= EDGE_B) base = EDGE_B;
      else if (ofs >= EDGE_A) base = EDGE_A;
    end
  end

  // R9: the block base never lies above the target offset
  assert_base_below_R9: assert property (@(posedge clk) disable iff (!rst_n)
    base <= ofs);

endmodule

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
  import nor_seq_pkg::*;
#(
  parameter int OFS_W  = 15,
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [2:0]        step,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [OFS_W-1:0]  base,
  input  logic [DATA_W-1:0] wdata,
  output logic [OFS_W-1:0]  addr,
  output logic [DATA_W-1:0] data
);
  localparam int PADW = DATA_W - 8;

  function automatic logic [DATA_W-1:0] ext(logic [7:0] c);
    ext = {{PADW{1'b0}}, c};
  endfunction

  always_comb begin
    addr = ofs;
    data = '0;
    if (op == OP_RESET) begin
      addr = ofs;
      data = ext(CODE_RDARR);
    end else begin
      case (step)
        3'd0: begin addr = OFS_W'(UNLOCK_HI); data = ext(CODE_KEY1); end
        3'd1: begin addr = OFS_W'(UNLOCK_LO); data = ext(CODE_KEY2); end
        3'd2: begin
          addr = OFS_W'(UNLOCK_HI);
          data = (op == OP_PROG) ? ext(CODE_PRSET) : ext(CODE_ERSET);
        end
        3'd3: begin
          if (op == OP_PROG) begin addr = ofs; data = wdata; end
          else begin addr = OFS_W'(UNLOCK_HI); data = ext(CODE_KEY1); end
        end
        3'd4: begin addr = OFS_W'(UNLOCK_LO); data = ext(CODE_KEY2); end
        default: begin
          if (op == OP_CERASE) begin
            addr = OFS_W'(UNLOCK_HI); data = ext(CODE_CHIPCF);
          end else begin
            addr = base; data = ext(CODE_BLKCF);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
  import nor_seq_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int OFS_W      = 15,
  parameter int DATA_W     = 16,
  parameter int GAP_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [PAGE_W+OFS_W-1:0] req_addr,
  input  logic [DATA_W-1:0]       req_data,
  output logic [PAGE_W-1:0]       fl_page,
  output logic [OFS_W-1:0]        fl_addr,
  output logic [DATA_W-1:0]       fl_data,
  output logic                    fl_we,
  output logic                    done
);
  localparam int AW = PAGE_W + OFS_W;

  st_e               st;
  op_e               op_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        step_q;
  logic [OFS_W-1:0]  blk_base;
  logic              gap_done;
  logic              accept;
  logic              last_step;

  assign accept    = req_valid && (st == S_IDLE);
  assign last_step = (step_q == op_len(op_q) - 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_RESET;
      page_q <= '0;
      ofs_q  <= '0;
      data_q <= '0;
      step_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= op_e'(req_op);
          page_q <= req_addr[AW-1:OFS_W];
          ofs_q  <= req_addr[OFS_W-1:0];
          data_q <= req_data;
          step_q <= '0;
          st     <= S_STROBE;
        end
        S_STROBE: st <= S_WAIT;
        S_WAIT: if (gap_done) begin
          if (last_step) st <= S_DONE;
          else begin
            step_q <= step_q + 3'd1;
            st     <= S_STROBE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  nor_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st == S_WAIT),
    .expired (gap_done)
  );

  nor_blk_base #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .page  (page_q),
    .ofs   (ofs_q),
    .base  (blk_base)
  );

  nor_cmd_table #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_tab (
    .op    (op_q),
    .step  (step_q),
    .ofs   (ofs_q),
    .base  (blk_base),
    .wdata (data_q),
    .addr  (fl_addr),
    .data  (fl_data)
  );

  assign req_ready = (st == S_IDLE);
  assign fl_we     = (st == S_STROBE);
  assign done      = (st == S_DONE);
  assign fl_page   = page_q;

  // R1: accepted request produces a strobe in the next cycle
  assert_accept_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> fl_we);

  // R6: write strobe lasts one clock
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we);

  // R7: done is a single pulse followed by idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R10: never ready while writing
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> !req_ready);

  // R8: page holds across a running operation
  assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(fl_page));

endmodule

// File: tb/tb_nor_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_nor_cmd_sequencer;
  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [18:0] req_addr;
  logic [15:0] req_data;
  logic [3:0]  fl_page;
  logic [14:0] fl_addr;
  logic [15:0] fl_data;
  logic        fl_we;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_done_cyc = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  nor_cmd_sequencer #(.GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .fl_page(fl_page), .fl_addr(fl_addr), .fl_data(fl_data),
    .fl_we(fl_we), .done(done)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, expv);
    end
  endtask

  function automatic int exp_len(input logic [1:0] op);
    return (op == 2'd0) ? 1 : (op == 2'd1) ? 4 : 6;
  endfunction

  function automatic logic [14:0] exp_base(input logic [3:0] pg, input logic [14:0] o);
    if (pg != 4'd0)      return 15'h0000;
    if (o < 15'h2000)    return 15'h0000;
    if (o < 15'h3000)    return 15'h2000;
    if (o < 15'h4000)    return 15'h3000;
    return 15'h4000;
  endfunction

  function automatic logic [14:0] exp_addr(input logic [1:0] op, input int k,
                                           input logic [18:0] a);
    if (op == 2'd0) return a[14:0];
    case (k)
      0, 2: return 15'h5555;
      1, 4: return 15'h2AAA;
      3:    return (op == 2'd1) ? a[14:0] : 15'h5555;
      default: return (op == 2'd3) ? 15'h5555 : exp_base(a[18:15], a[14:0]);
    endcase
  endfunction

  function automatic logic [15:0] exp_data(input logic [1:0] op, input int k,
                                           input logic [15:0] d);
    if (op == 2'd0) return 16'h00F0;
    case (k)
      0, 3: return (op == 2'd1 && k == 3) ? d : 16'h00AA;
      1, 4: return 16'h0055;
      2:    return (op == 2'd1) ? 16'h00A0 : 16'h0080;
      default: return (op == 2'd3) ? 16'h0010 : 16'h0030;
    endcase
  endfunction

  function automatic string op_req(input logic [1:0] op);
    case (op)
      2'd0: return "R5";
      2'd1: return "R4";
      2'd2: return "R2";
      default: return "R3";
    endcase
  endfunction

  // Drive request fields at a negedge; caller then runs watch()
  task automatic present(input logic [1:0] op, input logic [18:0] a, input logic [15:0] d);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
  endtask

  task automatic watch(input bit inject, input bit chained, input bit chain_next,
                       input logic [1:0] nop, input logic [18:0] na, input logic [15:0] nd);
    logic [1:0]  op;
    logic [18:0] a;
    logic [15:0] d;
    int n, k, dn;
    bit fin;
    op = req_op; a = req_addr; d = req_data;
    n = exp_len(op); k = 0; fin = 0;
    dn = 1 + n * (GAP + 1);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 1; t <= dn + 2 && !fin; t++) begin
      if (t > 1) @(negedge clk);
      if (inject && t == 2) begin
        req_valid = 1'b1; req_op = 2'd3; req_addr = 19'h7FFFF; req_data = 16'h1111;
      end
      if (inject && t == 3) req_valid = 1'b0;
      if (fl_we) begin
        chk(t == 1 + k * (GAP + 1), "R6", "strobe timing", t, 1 + k * (GAP + 1));
        chk(k < n, "R10", "extra write", k, n - 1);
        if (k < n) begin
          chk(fl_addr == exp_addr(op, k, a), op_req(op), "addr", fl_addr, exp_addr(op, k, a));
          chk(fl_data == exp_data(op, k, d), op_req(op), "data", fl_data, exp_data(op, k, d));
          chk(fl_page == a[18:15], "R8", "page", fl_page, a[18:15]);
        end
        if (k == 0 && chained)
          chk(cyc == last_done_cyc + 2, "R1", "chained first strobe", cyc, last_done_cyc + 2);
        k++;
      end
      if (done) begin
        chk(t == dn, "R7", "done timing", t, dn);
        chk(k == n, "R10", "write count", k, n);
        chk(!req_ready, "R7", "ready during done", req_ready, 0);
        last_done_cyc = cyc;
        if (chain_next) present(nop, na, nd);
        fin = 1;
      end else if (t < dn) begin
        if (req_ready) chk(0, "R1", "ready while busy", 1, 0);
      end
    end
    chk(fin, "R7", "done seen", fin, 1);
    if (!chain_next) begin
      @(negedge clk);
      chk(req_ready && !done && !fl_we, "R7", "idle after done",
          {req_ready, done, fl_we}, 3'b100);
    end
  endtask

  task automatic run1(input logic [1:0] op, input logic [18:0] a, input logic [15:0] d);
    present(op, a, d);
    watch(0, 0, 0, 2'd0, 19'd0, 16'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog act=%0d exp=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_data = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !fl_we && !done, "R11", "reset state", {req_ready, fl_we, done}, 3'b100);

    // Directed: each operation
    run1(2'd0, {4'd3, 15'h1357}, 16'h0000);           // R5
    run1(2'd1, {4'd9, 15'h7FFF}, 16'hFFFF);           // R4
    run1(2'd3, {4'd0, 15'h0000}, 16'h0000);           // R3
    // R9 block base corners on page 0 and one other page
    run1(2'd2, {4'd0, 15'h1FFF}, 16'h0);
    run1(2'd2, {4'd0, 15'h2000}, 16'h0);
    run1(2'd2, {4'd0, 15'h2FFF}, 16'h0);
    run1(2'd2, {4'd0, 15'h3000}, 16'h0);
    run1(2'd2, {4'd0, 15'h3FFF}, 16'h0);
    run1(2'd2, {4'd0, 15'h4000}, 16'h0);
    run1(2'd2, {4'd0, 15'h7FFF}, 16'h0);
    run1(2'd2, {4'd5, 15'h1234}, 16'h0);

    // R10: request arrives mid-sequence and is withdrawn
    present(2'd1, {4'd2, 15'h0042}, 16'hBEEF);
    watch(1, 0, 0, 2'd0, 19'd0, 16'd0);

    // R1/R7: next request presented in the done cycle
    present(2'd2, {4'd0, 15'h2345}, 16'h0);
    watch(0, 0, 1, 2'd1, {4'd7, 15'h0ABC}, 16'hCAFE);
    watch(0, 1, 0, 2'd0, 19'd0, 16'd0);

    // Constrained random
    for (int i = 0; i < 30; i++) begin
      logic [1:0]  op;
      logic [3:0]  pg;
      logic [14:0] o;
      op = 2'($urandom_range(0, 3));
      pg = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
      o  = 15'($urandom);
      run1(op, {pg, o}, 16'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule